// File: doc/BRIEF.md
# Multi-Rail Reset Release Sequencer

This block watches one power-good input per supply rail and drives a single active-low system reset. Each input first passes through a blanking filter, so a short pulse or a short dropout never reaches the release decision. The filtered inputs are combined under a selectable policy. Any-rail mode needs at least one critical rail to be good. All-rails mode needs every mandatory rail to be good. The reset is released only after this combined condition has held, without a break, for one shared release delay.

After the release, a hold window keeps the watchdog-enable output low, which gives slow peripherals a fixed grace period before supervision starts. In any-rail mode, a pre-release flag tells early-boot logic that a critical rail has arrived while the reset is still held. If the condition is lost after the release, the reset returns at once, and a new sequence needs the full delay again.

The delay is chosen from four bins. The hold length is a multiple of a fixed step. Both come from a small timing register, and its power-on value is the safe 100 ms bin. That register can only be changed while the reset is asserted. A write made after the release is parked and applied when the next sequence begins.

Top module: `rail_reset_sequencer`

## Requirements
- R1: After a synchronous reset (`rst_n` low on a clock edge), `sys_rst_n`, `wdt_en`, `pre_release` and every `rail_good` bit are 0. The timing register holds delay code 3 and hold units `HOLD_DEF`.
- R2: A `rail_good` bit follows its `pg_raw` bit only after the raw value has differed from it on `BLANK_MS*CYC_PER_MS` consecutive rising edges. It changes on the last of those edges. A shorter pulse or dropout leaves it unchanged.
- R3: With `agg_all`=0, the release condition is that at least one rail with its `crit_mask` bit set is filtered-good. Rails whose mask bit is 0 have no effect. `pre_release` is 1 exactly while this condition holds and the reset is asserted.
- R4: With `agg_all`=1, the release condition is that every rail with its `crit_mask` bit set is filtered-good. Rails whose mask bit is 0 have no effect, and `pre_release` stays 0. An all-zero mask never releases.
- R5: `sys_rst_n` rises D clock edges after the edge on which the condition became true. D = B*`CYC_PER_MS`, where B is 40, 80, 120 or 100 for delay codes 0, 1, 2 and 3.
- R6: If the condition drops during the delay count, `sys_rst_n` stays 0. The count restarts from zero, so a full D is needed after the condition returns.
- R7: If the condition is lost after the release, `sys_rst_n` and `wdt_en` go to 0 in the same cycle the filtered inputs change. The next release again needs a full D.
- R8: `wdt_en` rises max(H,1) edges after `sys_rst_n` rises, where H = hold units * `HOLD_STEP_MS` * `CYC_PER_MS`. `wdt_en` is never 1 while `sys_rst_n` is 0.
- R9: A register write (`cfg_we`=1) made while the reset is asserted takes effect on the next edge. A write made after the release does not alter the running sequence. It is applied once the reset has been asserted again.
- R10: A dropout shorter than the blanking time after the release leaves `sys_rst_n` and `wdt_en` at 1. One power-up sequence gives exactly one release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| pg_raw | input | N_RAILS | Power-good input for each rail, synchronous to clk |
| agg_all | input | 1 | 0: any critical rail releases; 1: all mandatory rails required |
| crit_mask | input | N_RAILS | Rails that take part in the release condition |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_delay_code | input | 2 | Release delay bin code |
| cfg_hold_units | input | HOLD_W | Watchdog hold length in steps |
| sys_rst_n | output | 1 | Active-low system reset |
| pre_release | output | 1 | A critical rail is good while the reset is still held (any-rail mode) |
| wdt_en | output | 1 | Watchdog supervision enable |
| rail_good | output | N_RAILS | Filtered power-good bit for each rail |

## Verification
The bench builds the block with `CYC_PER_MS`=1, `BLANK_MS`=5, `HOLD_STEP_MS`=10 and `HOLD_DEF`=2. The delay bins then become 40, 80, 120 and 100 cycles, the blanking window 5 cycles, and the default hold 20 cycles. At this scale, every bin and every hold length can be followed edge by edge. The bench can place glitches of four cycles against a five-cycle window, and it can drop a rail in the middle of a 40-cycle count. It can also park a register write inside a 10-cycle hold window and watch it apply to the following sequence.

// File: rtl/rrs_pkg.sv
// Shared types and helpers for the multi-rail reset release sequencer.
// Assumes: delay codes are 2 bits wide; code 3 is the safe power-on bin.
package rrs_pkg;

    typedef enum logic [1:0] {
        ST_HELD  = 2'd0,   // reset asserted, counting the release delay
        ST_GRACE = 2'd1,   // reset released, watchdog still held off
        ST_RUN   = 2'd2    // reset released, watchdog supervision on
    } rrs_state_e;

    localparam logic [1:0] DLY_CODE_SAFE = 2'd3;

    // Length of a release delay bin in milliseconds.
    function automatic int unsigned delay_bin_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 40;
            2'd1:    return 80;
            2'd2:    return 120;
            default: return 100;
        endcase
    endfunction

endpackage

// File: rtl/rrs_glitch_blank.sv
// Blanking filter for one power-good input.
// What it does: the filtered output takes the raw value only after the raw
// value has differed from it on BLANK_CYC consecutive clock edges.
// Assumes: raw_in is already synchronous to clk.
module rrs_glitch_blank #(
    parameter int unsigned BLANK_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic filt_out
);

    generate
        if (BLANK_CYC <= 1) begin : g_plain
            // Purpose: no blanking asked for, so follow the input after one flop.
            always_ff @(posedge clk) begin
                if (!rst_n) filt_out <= 1'b0;
                else        filt_out <= raw_in;
            end
        end else begin : g_count
            localparam int BW = $clog2(BLANK_CYC + 1);
            localparam logic [BW-1:0] LAST = BW'(BLANK_CYC - 1);
            logic [BW-1:0] run_q;

            // Purpose: count the edges on which raw differs from filtered; flip on the last one.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q    <= '0;
                    filt_out <= 1'b0;
                end else if (raw_in != filt_out) begin
                    if (run_q == LAST) begin
                        filt_out <= raw_in;
                        run_q    <= '0;
                    end else begin
                        run_q <= run_q + 1'b1;
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end
    endgenerate

    // R2
    follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_out != $past(filt_out)) |-> (filt_out == $past(raw_in)));

endmodule

// File: rtl/rrs_timing_cfg.sv
// Timing register for the release delay bin and the watchdog hold length.
// What it does: writes go straight into the active register while unlocked.
// While locked, writes are parked and copied across at the first unlocked edge.
// Assumes: locked is 1 exactly while the reset output is released.
module rrs_timing_cfg
    import rrs_pkg::*;
#(
    parameter int unsigned CYC_PER_MS   = 1000,
    parameter int unsigned HOLD_STEP_MS = 10,
    parameter int unsigned HOLD_W       = 4,
    parameter int unsigned HOLD_DEF     = 2,
    parameter int unsigned CNT_W        = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              wr_en,
    input  logic [1:0]        wr_delay_code,
    input  logic [HOLD_W-1:0] wr_hold_units,
    output logic [CNT_W-1:0]  delay_cyc,
    output logic [CNT_W-1:0]  hold_cyc
);

    localparam int unsigned HOLD_CYC_STEP = HOLD_STEP_MS * CYC_PER_MS;

    logic [1:0]        dly_q, dly_pend_q;
    logic [HOLD_W-1:0] hold_q, hold_pend_q;
    logic              pend_q;

    // Purpose: keep the active values, and park the writes made while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q       <= DLY_CODE_SAFE;
            hold_q      <= HOLD_W'(HOLD_DEF);
            dly_pend_q  <= DLY_CODE_SAFE;
            hold_pend_q <= HOLD_W'(HOLD_DEF);
            pend_q      <= 1'b0;
        end else if (!locked) begin
            if (wr_en) begin
                dly_q  <= wr_delay_code;
                hold_q <= wr_hold_units;
                pend_q <= 1'b0;
            end else if (pend_q) begin
                dly_q  <= dly_pend_q;
                hold_q <= hold_pend_q;
                pend_q <= 1'b0;
            end
        end else if (wr_en) begin
            dly_pend_q  <= wr_delay_code;
            hold_pend_q <= wr_hold_units;
            pend_q      <= 1'b1;
        end
    end

    // Purpose: turn the codes into clock-cycle counts.
    always_comb begin
        delay_cyc = CNT_W'(delay_bin_ms(dly_q) * CYC_PER_MS);
        hold_cyc  = CNT_W'(32'(hold_q) * HOLD_CYC_STEP);
    end

    // R9
    locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> ($stable(dly_q) && $stable(hold_q)));

endmodule

// File: rtl/rrs_release_ctrl.sv
// Release arbiter: combines the rails, counts the release delay and the hold.
// What it does: in ST_HELD it counts consecutive edges on which the
// condition holds and releases at delay_cyc. In ST_GRACE it counts the hold
// and then enables the watchdog. Losing the condition returns to ST_HELD.
// Assumes: rail_good is already blanked; delay_cyc is never zero.
module rrs_release_ctrl
    import rrs_pkg::*;
#(
    parameter int unsigned N_RAILS = 4,
    parameter int unsigned CNT_W   = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] rail_good,
    input  logic [N_RAILS-1:0] crit_mask,
    input  logic               agg_all,
    input  logic [CNT_W-1:0]   delay_cyc,
    input  logic [CNT_W-1:0]   hold_cyc,
    output logic               locked,
    output logic               sys_rst_n,
    output logic               pre_release,
    output logic               wdt_en
);

    rrs_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_nxt;
    logic             cond_any, cond_all, cond;

    // Purpose: evaluate the any-rail and all-rails conditions over the critical rails.
    always_comb begin
        cond_any = |(rail_good & crit_mask);
        cond_all = (crit_mask != '0) && ((rail_good & crit_mask) == crit_mask);
        cond     = agg_all ? cond_all : cond_any;
        cnt_nxt  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    end

    // Purpose: step the sequence and its shared delay/hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HELD;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_HELD: begin
                    if (!cond) begin
                        cnt_q <= '0;
                    end else if (cnt_nxt >= {1'b0, delay_cyc}) begin
                        state_q <= ST_GRACE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_nxt[CNT_W-1:0];
                    end
                end
                ST_GRACE: begin
                    if (!cond) begin
                        state_q <= ST_HELD;
                        cnt_q   <= '0;
                    end else if (cnt_nxt >= {1'b0, hold_cyc}) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_nxt[CNT_W-1:0];
                    end
                end
                ST_RUN: begin
                    if (!cond) begin
                        state_q <= ST_HELD;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    state_q <= ST_HELD;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Purpose: drive the outputs; a lost condition pulls the reset in the same cycle.
    always_comb begin
        locked      = (state_q != ST_HELD);
        sys_rst_n   = locked && cond;
        wdt_en      = (state_q == ST_RUN) && cond;
        pre_release = !agg_all && (state_q == ST_HELD) && cond_any;
    end

    // Independent run-length of the condition, used only by the checks below.
    logic [CNT_W:0] held_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 held_q <= '0;
        else if (!cond)             held_q <= '0;
        else if (held_q != '1)      held_q <= held_q + 1'b1;
    end

    // R5
    release_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (held_q >= {1'b0, $past(delay_cyc)}));

    // R8
    wdt_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_en |-> sys_rst_n);

    // R8
    wdt_rise_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_en) |-> $past(sys_rst_n));

    // R3
    prerelease_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_release |-> !sys_rst_n);

endmodule

// File: rtl/rail_reset_sequencer.sv
// Top level of the multi-rail reset release sequencer.
// What it does: blanks each power-good input, then passes the filtered
// rails to the release arbiter, which uses the lengths held in the timing register.
// Assumes: pg_raw is synchronous to clk; rst_n is synchronous, active low.
module rail_reset_sequencer #(
    parameter int unsigned N_RAILS      = 4,
    parameter int unsigned CYC_PER_MS   = 1000,
    parameter int unsigned BLANK_MS     = 5,
    parameter int unsigned HOLD_STEP_MS = 10,
    parameter int unsigned HOLD_W       = 4,
    parameter int unsigned HOLD_DEF     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] pg_raw,
    input  logic               agg_all,
    input  logic [N_RAILS-1:0] crit_mask,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_delay_code,
    input  logic [HOLD_W-1:0]  cfg_hold_units,
    output logic               sys_rst_n,
    output logic               pre_release,
    output logic               wdt_en,
    output logic [N_RAILS-1:0] rail_good
);

    localparam int unsigned BLANK_CYC = BLANK_MS * CYC_PER_MS;
    localparam int unsigned MAX_DLY   = 120 * CYC_PER_MS;
    localparam int unsigned MAX_HOLD  = ((1 << HOLD_W) - 1) * HOLD_STEP_MS * CYC_PER_MS;
    localparam int unsigned MAX_CYC   = (MAX_DLY > MAX_HOLD) ? MAX_DLY : MAX_HOLD;
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] delay_cyc, hold_cyc;
    logic             locked;

    // One blanking filter per rail.
    for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
        rrs_glitch_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (pg_raw[g]),
            .filt_out (rail_good[g])
        );
    end

    rrs_timing_cfg #(
        .CYC_PER_MS   (CYC_PER_MS),
        .HOLD_STEP_MS (HOLD_STEP_MS),
        .HOLD_W       (HOLD_W),
        .HOLD_DEF     (HOLD_DEF),
        .CNT_W        (CNT_W)
    ) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .locked        (locked),
        .wr_en         (cfg_we),
        .wr_delay_code (cfg_delay_code),
        .wr_hold_units (cfg_hold_units),
        .delay_cyc     (delay_cyc),
        .hold_cyc      (hold_cyc)
    );

    rrs_release_ctrl #(
        .N_RAILS (N_RAILS),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rail_good   (rail_good),
        .crit_mask   (crit_mask),
        .agg_all     (agg_all),
        .delay_cyc   (delay_cyc),
        .hold_cyc    (hold_cyc),
        .locked      (locked),
        .sys_rst_n   (sys_rst_n),
        .pre_release (pre_release),
        .wdt_en      (wdt_en)
    );

endmodule

// File: tb/rail_reset_sequencer_tb.sv
// Directed bench for rail_reset_sequencer: one task per scenario.
module rail_reset_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pg_raw = '0;
    logic         agg_all = 1'b0;
    logic [N-1:0] crit_mask = '0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_delay_code = '0;
    logic [3:0]   cfg_hold_units = '0;
    logic         sys_rst_n, pre_release, wdt_en;
    logic [N-1:0] rail_good;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_reset_sequencer #(
        .N_RAILS(N), .CYC_PER_MS(1), .BLANK_MS(5),
        .HOLD_STEP_MS(10), .HOLD_W(4), .HOLD_DEF(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pg_raw(pg_raw), .agg_all(agg_all),
        .crit_mask(crit_mask), .cfg_we(cfg_we), .cfg_delay_code(cfg_delay_code),
        .cfg_hold_units(cfg_hold_units), .sys_rst_n(sys_rst_n),
        .pre_release(pre_release), .wdt_en(wdt_en), .rail_good(rail_good)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic mode, input logic [N-1:0] mask);
        @(negedge clk);
        agg_all = mode; crit_mask = mask; pg_raw = '0; cfg_we = 1'b0;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [1:0] code, input logic [3:0] units);
        cfg_delay_code = code; cfg_hold_units = units; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset_state();
        do_reset(1'b0, 4'b0001);
        chk("R1 sys_rst_n", 32'(sys_rst_n), 0);
        chk("R1 wdt_en", 32'(wdt_en), 0);
        chk("R1 pre_release", 32'(pre_release), 0);
        chk("R1 rail_good", 32'(rail_good), 0);
    endtask

    // R1 defaults, R2, R3, R5, R8, R10, R7 in any-rail mode
    task automatic t_default_sequence();
        do_reset(1'b0, 4'b0001);
        pg_raw[0] = 1'b1; tick(4); pg_raw[0] = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick(1); chk("R2 short pulse ignored", 32'(rail_good[0]), 0);
        end
        pg_raw[0] = 1'b1;
        tick(4); chk("R2 not yet", 32'(rail_good[0]), 0);
        tick(1); chk("R2 after blank", 32'(rail_good[0]), 1);
        chk("R3 pre_release on", 32'(pre_release), 1);
        tick(99); chk("R5 R1 default bin before", 32'(sys_rst_n), 0);
        tick(1); chk("R5 R1 default bin release", 32'(sys_rst_n), 1);
        chk("R3 pre_release off", 32'(pre_release), 0);
        chk("R8 wdt low at release", 32'(wdt_en), 0);
        tick(19); chk("R8 R1 default hold before", 32'(wdt_en), 0);
        tick(1); chk("R8 R1 default hold done", 32'(wdt_en), 1);
        pg_raw[0] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1); chk("R10 glitch keeps release", 32'(sys_rst_n), 1);
        end
        pg_raw[0] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(1); chk("R10 wdt held", 32'(wdt_en), 1);
        end
        pg_raw[0] = 1'b0;
        tick(4); chk("R7 before loss", 32'(sys_rst_n), 1);
        tick(1); chk("R7 rail lost", 32'(rail_good[0]), 0);
        chk("R7 reset reasserted", 32'(sys_rst_n), 0);
        chk("R7 wdt dropped", 32'(wdt_en), 0);
        pg_raw[0] = 1'b1; tick(5);
        tick(99); chk("R7 full delay again before", 32'(sys_rst_n), 0);
        tick(1); chk("R7 full delay again release", 32'(sys_rst_n), 1);
    endtask

    // R3 mask, R9 write during reset, R5 bin 0
    task automatic t_any_mask();
        do_reset(1'b0, 4'b0110);
        cfg_write(2'd0, 4'd2);
        pg_raw[3] = 1'b1; tick(60);
        chk("R3 non-critical ignored pre", 32'(pre_release), 0);
        chk("R3 non-critical ignored rst", 32'(sys_rst_n), 0);
        pg_raw[2] = 1'b1; tick(5);
        chk("R3 critical rail tags", 32'(pre_release), 1);
        tick(39); chk("R9 R5 bin0 before", 32'(sys_rst_n), 0);
        tick(1); chk("R9 R5 bin0 release", 32'(sys_rst_n), 1);
    endtask

    // R4 all-rails mode, R5 bin 1
    task automatic t_all_mode();
        do_reset(1'b1, 4'b0011);
        cfg_write(2'd1, 4'd2);
        pg_raw[0] = 1'b1; pg_raw[2] = 1'b1; tick(100);
        chk("R4 no tag in all mode", 32'(pre_release), 0);
        chk("R4 partial rails held", 32'(sys_rst_n), 0);
        pg_raw[1] = 1'b1; tick(5);
        tick(79); chk("R4 R5 bin1 before", 32'(sys_rst_n), 0);
        tick(1); chk("R4 R5 bin1 release", 32'(sys_rst_n), 1);
        pg_raw[2] = 1'b0; tick(10);
        chk("R4 optional rail drop ignored", 32'(sys_rst_n), 1);
    endtask

    // R6 condition lost during the count
    task automatic t_drop_during_count();
        do_reset(1'b1, 4'b0011);
        cfg_write(2'd0, 4'd2);
        pg_raw[0] = 1'b1; pg_raw[1] = 1'b1; tick(5);
        tick(20);
        pg_raw[1] = 1'b0; tick(6);
        chk("R6 held during drop", 32'(sys_rst_n), 0);
        pg_raw[1] = 1'b1;
        tick(4); chk("R6 rail still low", 32'(rail_good[1]), 0);
        tick(1); chk("R6 rail back", 32'(rail_good[1]), 1);
        tick(14); chk("R6 no release at old time", 32'(sys_rst_n), 0);
        tick(25); chk("R6 restart before", 32'(sys_rst_n), 0);
        tick(1); chk("R6 restart release", 32'(sys_rst_n), 1);
    endtask

    // R9 write after release is deferred to the next sequence
    task automatic t_cfg_lock();
        do_reset(1'b0, 4'b0001);
        cfg_write(2'd0, 4'd1);
        pg_raw[0] = 1'b1; tick(5);
        tick(39); chk("R9 first bin before", 32'(sys_rst_n), 0);
        tick(1); chk("R9 first bin release", 32'(sys_rst_n), 1);
        tick(1);
        cfg_write(2'd2, 4'd3);
        tick(7); chk("R9 old hold kept before", 32'(wdt_en), 0);
        tick(1); chk("R9 old hold kept done", 32'(wdt_en), 1);
        pg_raw[0] = 1'b0; tick(5);
        chk("R9 reset back", 32'(sys_rst_n), 0);
        tick(5);
        pg_raw[0] = 1'b1; tick(5);
        chk("R9 rail good again", 32'(rail_good[0]), 1);
        tick(119); chk("R9 parked bin before", 32'(sys_rst_n), 0);
        tick(1); chk("R9 parked bin release", 32'(sys_rst_n), 1);
        tick(29); chk("R9 parked hold before", 32'(wdt_en), 0);
        tick(1); chk("R9 parked hold done", 32'(wdt_en), 1);
    endtask

    initial begin
        t_reset_state();
        t_default_sequence();
        t_any_mask();
        t_all_mode();
        t_drop_during_count();
        t_cfg_lock();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule